// File: doc/BRIEF.md
# Host Channel Control Register Bank

This block keeps the per-channel control words for a USB host with a parameterised number of transfer channels (twelve by default). Each channel has one control word on a simple register bus. The word holds a run bit, a stop-request bit, a periodic-frame parity flag and a 7-bit target device address. Each channel also has a status word that holds a sticky halted flag. The control outputs go directly to the transfer engine. The engine pulses back when a channel's transfer completes or when the channel has stopped in response to a stop request.

Software starts a channel by writing its run bit. Only hardware ends a channel. A completion pulse or a halt pulse clears both the run bit and the stop request. A halt pulse also raises the channel's halted flag, which drives a combined interrupt. Software that has asked for a stop must wait for that flag before it treats the channel as idle. The flag stays set until software writes a 1 to it.

Top module: `host_chan_regs`

## Requirements
- R1: After reset every control word and every status word reads zero, and `ch_en_o`, `ch_dis_o`, `ch_odd_o`, `ch_dev_addr_o`, `ch_halt_flag_o` and `irq_o` are all low.
- R2: The control word of channel n sits at byte address 0x500 + n*0x20. Its layout is bit 31 run, bit 30 stop request, bit 29 odd frame, and bits 28:22 device address. Bits 21:0 always read zero. Read data appears on `bus_rdata_o` in the cycle after the read request and is zero in any cycle that follows no read. A write to one channel changes no other channel.
- R3: Every write to a control word loads the odd-frame bit and the device address from the write data. These values appear on `ch_odd_o` and `ch_dev_addr_o` (7 bits per channel, channel n at bits 7n+6:7n) and read back unchanged.
- R4: Writing 1 to bit 31 sets the run bit. Writing 0 to bit 31 leaves it unchanged.
- R5: Writing 1 to bit 30 sets the stop request. Writing 0 to bit 30 leaves it unchanged.
- R6: A one-cycle pulse on `eng_done_i[n]` clears channel n's run bit and stop request at the next clock edge. It does not set the halted flag.
- R7: A one-cycle pulse on `eng_halt_i[n]` clears the run bit and the stop request, and sets the halted flag. The flag reads as bit 1 of the status word at 0x500 + n*0x20 + 0x08 and drives `irq_o`. A hardware clear takes priority over a software write in the same cycle.
- R8: The halted flag is sticky. Writing 1 to status bit 1 clears it, and writing 0 has no effect. A halt pulse in the same cycle as a clearing write leaves the flag set.
- R9: Any other address, inside or outside the channel window, reads zero, and writes to it change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_req_i | input | 1 | Bus access strobe, one cycle per access |
| bus_we_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | 12 | Byte address |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Registered read data |
| eng_done_i | input | 12 | Per-channel transfer-complete pulse |
| eng_halt_i | input | 12 | Per-channel halted-after-stop pulse |
| ch_en_o | output | 12 | Per-channel run bit |
| ch_dis_o | output | 12 | Per-channel stop request |
| ch_odd_o | output | 12 | Per-channel odd-frame flag |
| ch_dev_addr_o | output | 84 | Per-channel device address, 7 bits each |
| ch_halt_flag_o | output | 12 | Per-channel sticky halted flag |
| irq_o | output | 1 | OR of all halted flags |

## Verification
The assertions assume that the engine's done and halt inputs are single-cycle pulses sampled on the clock. They also assume that a bus strobe lasts one cycle with stable address and data. Under these assumptions a rise of the run or stop bit can only follow a write that carried that bit. The stimulus drives every input on the falling edge and holds it for exactly one cycle. It raises engine pulses only as isolated cycles, or deliberately in the same cycle as a bus write to exercise the priority rules.

// File: rtl/hchan_pkg.sv
package hchan_pkg;
  localparam int unsigned DATA_W     = 32;
  localparam int unsigned DEV_ADDR_W = 7;
  localparam int unsigned BIT_EN     = 31;
  localparam int unsigned BIT_DIS    = 30;
  localparam int unsigned BIT_ODD    = 29;
  localparam int unsigned DEV_LSB    = 22;
  localparam int unsigned STAT_WORD  = 8;   // status word byte offset in a slot
  localparam int unsigned BIT_HALT   = 1;

  // packed so that {cfg, zeros} is the control word image
  typedef struct packed {
    logic                  en;
    logic                  dis;
    logic                  odd;
    logic [DEV_ADDR_W-1:0] dev;
  } chan_cfg_t;

  localparam int unsigned CFG_W = $bits(chan_cfg_t);
endpackage

// File: rtl/hchan_dec.sv
module hchan_dec #(
  parameter int unsigned NCH       = 12,
  parameter int unsigned ADDR_W    = 12,
  parameter int unsigned BASE      = 'h500,
  parameter int unsigned STRIDE_LG = 5,
  localparam int unsigned CH_W     = $clog2(NCH)
) (
  input  logic [ADDR_W-1:0] addr_i,
  output logic [CH_W-1:0]   ch_o,
  output logic              hit_cfg_o,
  output logic              hit_stat_o
);
  import hchan_pkg::*;

  localparam logic [ADDR_W-1:0]    BASE_A = ADDR_W'(BASE);
  localparam logic [ADDR_W:0]      SPAN   = (ADDR_W+1)'(NCH) << STRIDE_LG;
  localparam logic [STRIDE_LG-1:0] W_STAT = STRIDE_LG'(STAT_WORD);

  logic [ADDR_W-1:0]    off;
  logic [STRIDE_LG-1:0] word;
  logic                 in_rng;

  assign off    = addr_i - BASE_A;
  assign in_rng = (addr_i >= BASE_A) && ({1'b0, off} < SPAN);
  assign word   = off[STRIDE_LG-1:0];
  assign ch_o   = off[STRIDE_LG +: CH_W];

  assign hit_cfg_o  = in_rng && (word == '0);
  assign hit_stat_o = in_rng && (word == W_STAT);
endmodule

// File: rtl/hchan_slot.sv
module hchan_slot
  import hchan_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      wr_cfg_i,
  input  chan_cfg_t wcfg_i,
  input  logic      wr_stat_i,
  input  logic      wclr_i,
  input  logic      done_i,
  input  logic      halt_i,
  output chan_cfg_t cfg_o,
  output logic      flag_o
);
  chan_cfg_t cfg_q;
  logic      flag_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q  <= '0;
      flag_q <= 1'b0;
    end else begin
      if (wr_cfg_i) begin
        cfg_q.odd <= wcfg_i.odd;
        cfg_q.dev <= wcfg_i.dev;
        if (wcfg_i.en)  cfg_q.en  <= 1'b1;
        if (wcfg_i.dis) cfg_q.dis <= 1'b1;
      end
      // engine clear wins over a same-cycle software set
      if (done_i || halt_i) begin
        cfg_q.en  <= 1'b0;
        cfg_q.dis <= 1'b0;
      end
      if (halt_i)                    flag_q <= 1'b1;
      else if (wr_stat_i && wclr_i)  flag_q <= 1'b0;
    end
  end

  assign cfg_o  = cfg_q;
  assign flag_o = flag_q;

  p_hw_clear_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_i || halt_i) |=> (!cfg_q.en && !cfg_q.dis));
  p_halt_flag_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    halt_i |=> flag_q);
  p_sticky_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag_q && !(wr_stat_i && wclr_i)) |=> flag_q);
  p_en_sw_set_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(cfg_q.en) |-> $past(wr_cfg_i && wcfg_i.en));
  p_dis_sw_set_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(cfg_q.dis) |-> $past(wr_cfg_i && wcfg_i.dis));
  p_cfg_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_cfg_i |=> $stable({cfg_q.odd, cfg_q.dev}));
endmodule

// File: rtl/hchan_rdmux.sv
module hchan_rdmux
  import hchan_pkg::*;
#(
  parameter int unsigned NCH  = 12,
  localparam int unsigned CH_W = $clog2(NCH)
) (
  input  chan_cfg_t          cfg_i [NCH],
  input  logic [NCH-1:0]     flag_i,
  input  logic [CH_W-1:0]    ch_i,
  input  logic               hit_cfg_i,
  input  logic               hit_stat_i,
  output logic [DATA_W-1:0]  data_o
);
  localparam logic [CH_W:0] NCH_L = (CH_W+1)'(NCH);

  always_comb begin
    data_o = '0;
    if ({1'b0, ch_i} < NCH_L) begin
      if (hit_cfg_i)  data_o = {cfg_i[ch_i], {(DATA_W-CFG_W){1'b0}}};
      if (hit_stat_i) data_o[BIT_HALT] = flag_i[ch_i];
    end
  end
endmodule

// File: rtl/host_chan_regs.sv
module host_chan_regs
  import hchan_pkg::*;
#(
  parameter int unsigned NCH       = 12,
  parameter int unsigned ADDR_W    = 12,
  parameter int unsigned BASE      = 'h500,
  parameter int unsigned STRIDE_LG = 5,
  localparam int unsigned CH_W     = $clog2(NCH)
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      bus_req_i,
  input  logic                      bus_we_i,
  input  logic [ADDR_W-1:0]         bus_addr_i,
  input  logic [DATA_W-1:0]         bus_wdata_i,
  output logic [DATA_W-1:0]         bus_rdata_o,
  input  logic [NCH-1:0]            eng_done_i,
  input  logic [NCH-1:0]            eng_halt_i,
  output logic [NCH-1:0]            ch_en_o,
  output logic [NCH-1:0]            ch_dis_o,
  output logic [NCH-1:0]            ch_odd_o,
  output logic [NCH*DEV_ADDR_W-1:0] ch_dev_addr_o,
  output logic [NCH-1:0]            ch_halt_flag_o,
  output logic                      irq_o
);
  logic [CH_W-1:0]   ch;
  logic              hit_cfg, hit_stat;
  chan_cfg_t         cfg [NCH];
  logic [NCH-1:0]    flags;
  chan_cfg_t         wcfg;
  logic [DATA_W-1:0] rd_mux, rdata_q;
  logic              rd_req;
  logic              unused_wbits;

  assign wcfg         = chan_cfg_t'(bus_wdata_i[DATA_W-1 -: CFG_W]);
  assign unused_wbits = ^{bus_wdata_i[DATA_W-CFG_W-1:BIT_HALT+1], bus_wdata_i[0]};
  assign rd_req       = bus_req_i && !bus_we_i;

  hchan_dec #(
    .NCH(NCH), .ADDR_W(ADDR_W), .BASE(BASE), .STRIDE_LG(STRIDE_LG)
  ) u_dec (
    .addr_i    (bus_addr_i),
    .ch_o      (ch),
    .hit_cfg_o (hit_cfg),
    .hit_stat_o(hit_stat)
  );

  for (genvar n = 0; n < NCH; n++) begin : g_ch
    logic sel;
    assign sel = bus_req_i && bus_we_i && (ch == CH_W'(n));

    hchan_slot u_slot (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .wr_cfg_i (sel && hit_cfg),
      .wcfg_i   (wcfg),
      .wr_stat_i(sel && hit_stat),
      .wclr_i   (bus_wdata_i[BIT_HALT]),
      .done_i   (eng_done_i[n]),
      .halt_i   (eng_halt_i[n]),
      .cfg_o    (cfg[n]),
      .flag_o   (flags[n])
    );

    assign ch_en_o[n]  = cfg[n].en;
    assign ch_dis_o[n] = cfg[n].dis;
    assign ch_odd_o[n] = cfg[n].odd;
    assign ch_dev_addr_o[n*DEV_ADDR_W +: DEV_ADDR_W] = cfg[n].dev;
  end

  hchan_rdmux #(.NCH(NCH)) u_rdmux (
    .cfg_i     (cfg),
    .flag_i    (flags),
    .ch_i      (ch),
    .hit_cfg_i (hit_cfg),
    .hit_stat_i(hit_stat),
    .data_o    (rd_mux)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rdata_q <= '0;
    else         rdata_q <= rd_req ? rd_mux : '0;
  end

  assign bus_rdata_o    = rdata_q;
  assign ch_halt_flag_o = flags;
  assign irq_o          = |flags;

  p_rd_undecoded_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_req && !hit_cfg && !hit_stat) |=> (bus_rdata_o == '0));
  p_rd_idle_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_req |=> (bus_rdata_o == '0));
  p_low_bits_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_req && hit_cfg) |=> (bus_rdata_o[DATA_W-CFG_W-1:0] == '0));
  p_dec_excl_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({hit_cfg, hit_stat}));
endmodule

// File: tb/host_chan_regs_tb.sv
module host_chan_regs_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NCH = 12;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0, we = 1'b0;
  logic [11:0] addr = '0;
  logic [31:0] wdata = '0, rdata;
  logic [NCH-1:0] done = '0, halt = '0;
  logic [NCH-1:0] en_o, dis_o, odd_o, flag_o;
  logic [NCH*7-1:0] dev_o;
  logic irq;
  int n_run = 0, n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  host_chan_regs u_dut (
    .clk_i(clk), .rst_ni(rst_n), .bus_req_i(req), .bus_we_i(we),
    .bus_addr_i(addr), .bus_wdata_i(wdata), .bus_rdata_o(rdata),
    .eng_done_i(done), .eng_halt_i(halt), .ch_en_o(en_o), .ch_dis_o(dis_o),
    .ch_odd_o(odd_o), .ch_dev_addr_o(dev_o), .ch_halt_flag_o(flag_o), .irq_o(irq)
  );

  task automatic chk(string r, logic [31:0] act, logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", r, act, exp);
    end
  endtask

  function automatic logic [11:0] ca(int n);
    return 12'h500 + 12'(n * 32);
  endfunction

  function automatic logic [31:0] cw(bit e, bit d, bit o, logic [6:0] dv);
    return {e, d, o, dv, 22'b0};
  endfunction

  task automatic wr(logic [11:0] a, logic [31:0] d);
    @(negedge clk); req = 1; we = 1; addr = a; wdata = d;
    @(negedge clk); req = 0; we = 0;
  endtask

  task automatic rd(logic [11:0] a, output logic [31:0] d);
    @(negedge clk); req = 1; we = 0; addr = a;
    @(negedge clk); req = 0; d = rdata;
  endtask

  task automatic pulse(bit is_halt, int n);
    @(negedge clk);
    if (is_halt) halt[n] = 1'b1; else done[n] = 1'b1;
    @(negedge clk); halt = '0; done = '0;
  endtask

  task automatic t_reset();
    logic [31:0] d;
    for (int n = 0; n < NCH; n++) begin
      rd(ca(n), d);     chk("R1 cfg", d, 0);
      rd(ca(n) + 8, d); chk("R1 stat", d, 0);
    end
    chk("R1 outs", {en_o, dis_o, odd_o, flag_o}, 0);
    chk("R1 dev", 32'(|dev_o), 0);
    chk("R1 irq", 32'(irq), 0);
  endtask

  task automatic t_map();
    logic [31:0] d;
    for (int n = 0; n < NCH; n++)
      wr(ca(n), cw(0, 0, n[0], 7'(n + 32)) | 32'h003F_FFFF);
    for (int n = 0; n < NCH; n++) begin
      rd(ca(n), d);
      chk("R2 map", d, cw(0, 0, n[0], 7'(n + 32)));
      chk("R3 dev out", 32'(dev_o[n*7 +: 7]), 32'(n + 32));
      chk("R3 odd out", 32'(odd_o[n]), 32'(n[0]));
    end
    @(negedge clk); chk("R2 idle rdata", rdata, 0);
  endtask

  task automatic t_run_stop();
    logic [31:0] d;
    wr(ca(3), cw(1, 0, 1, 7'h15));
    rd(ca(3), d); chk("R4 set", d, cw(1, 0, 1, 7'h15));
    chk("R2 isolate", 32'(en_o), 32'(1 << 3));
    wr(ca(3), cw(0, 0, 0, 7'h2A));
    rd(ca(3), d); chk("R4 write0 keeps", d, cw(1, 0, 0, 7'h2A));
    wr(ca(3), cw(0, 1, 0, 7'h2A));
    chk("R5 set", 32'(dis_o), 32'(1 << 3));
    wr(ca(3), cw(0, 0, 0, 7'h2A));
    rd(ca(3), d); chk("R5 write0 keeps", d, cw(1, 1, 0, 7'h2A));
  endtask

  task automatic t_done();
    logic [31:0] d;
    pulse(0, 3);
    rd(ca(3), d);     chk("R6 cleared", d, cw(0, 0, 0, 7'h2A));
    rd(ca(3) + 8, d); chk("R6 no flag", d, 0);
    chk("R6 irq", 32'(irq), 0);
  endtask

  task automatic t_halt();
    logic [31:0] d;
    wr(ca(5), cw(1, 1, 0, 7'h05));
    pulse(1, 5);
    chk("R7 en/dis", 32'({en_o[5], dis_o[5]}), 0);
    chk("R7 irq", 32'(irq), 1);
    rd(ca(5) + 8, d); chk("R7 flag", d, 32'h2);
  endtask

  task automatic t_w1c();
    logic [31:0] d;
    wr(ca(5) + 8, 32'hFFFF_FFFD);
    rd(ca(5) + 8, d); chk("R8 write0 keeps", d, 32'h2);
    wr(ca(5) + 8, 32'h2);
    rd(ca(5) + 8, d); chk("R8 cleared", d, 0);
    chk("R8 irq low", 32'(irq), 0);
  endtask

  task automatic t_collide();
    logic [31:0] d;
    @(negedge clk); req = 1; we = 1; addr = ca(6); wdata = cw(1, 1, 1, 7'h11); halt[6] = 1;
    @(negedge clk); req = 0; we = 0; halt = '0;
    rd(ca(6), d); chk("R7 hw wins", d, cw(0, 0, 1, 7'h11));
    chk("R7 flag set", 32'(flag_o[6]), 1);
    @(negedge clk); req = 1; we = 1; addr = ca(6) + 8; wdata = 32'h2; halt[6] = 1;
    @(negedge clk); req = 0; we = 0; halt = '0;
    rd(ca(6) + 8, d); chk("R8 set wins", d, 32'h2);
    wr(ca(6) + 8, 32'h2);
    chk("R8 clr", 32'(flag_o[6]), 0);
  endtask

  task automatic t_undec();
    logic [31:0] d;
    wr(ca(2) + 4, 32'hFFFF_FFFF);
    wr(ca(2) + 12'h10, 32'hFFFF_FFFF);
    wr(12'h4FC, 32'hFFFF_FFFF);
    wr(12'h680, 32'hFFFF_FFFF);
    rd(ca(2) + 4, d);     chk("R9 hole rd", d, 0);
    rd(ca(2) + 12'h1C, d); chk("R9 hole rd2", d, 0);
    rd(12'h680, d);       chk("R9 past end", d, 0);
    rd(12'h4E0, d);       chk("R9 below", d, 0);
    rd(ca(2), d);         chk("R9 no effect", d, cw(0, 0, 0, 7'h22));
    chk("R9 no flags", 32'(flag_o), 0);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_run++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_map();
    t_run_stop();
    t_done();
    t_halt();
    t_w1c();
    t_collide();
    t_undec();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule